// File: doc/BRIEF.md
# Folded Six-Tap Symmetric FIR Filter

This block is a streaming FIR filter with six taps whose coefficients mirror around the centre: the outermost pair shares one weight, the next pair a second, and the two centre taps a third. Because mirrored taps share a weight, the two samples of each pair are added before they are multiplied. Three multipliers then do the work of six.

Samples enter on a valid/ready stream and filtered results leave on a second valid/ready stream. Each accepted sample moves the whole pipeline forward by one step and produces exactly one result beat. Idle cycles and back-pressure leave the filter history untouched, so the output depends only on the sequence of accepted samples and never on the timing of the handshakes. Back-pressure rules are simple. A result that is offered but not taken stays on the port unchanged. While that result waits, the input side drops ready. The input is ready whenever no result is waiting, or when the waiting result is being taken in the same cycle.

Inside, the samples run along a delay line whose taps are two steps apart and feed the pre-adders. A fixed tap at the far end of the line supplies the mirrored partner of every pair. The pre-adder sums and the products are registered. A registered summing chain, one step per stage, then combines the three products into the result.

Top module: `symfir_top`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the sample history and every pipeline register: afterwards out_valid is 0, in_ready is 1 and out_data is 0, and the following results are computed as if all earlier samples were zero.
- R2: A sample is accepted at a rising edge where in_valid and in_ready are both 1. in_ready is 1 when out_valid is 0 or out_ready is 1, and is 0 while a result is waiting with out_ready low.
- R3: Every accepted sample produces exactly one result beat: out_valid is 1 in the cycle after the acceptance.
- R4: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data holds its value.
- R5: With x(m) the m-th accepted sample (earlier samples treated as zero), the beat produced by x(m) equals k0*(x(m-4)+x(m-9)) + k1*(x(m-5)+x(m-8)) + k2*(x(m-6)+x(m-7)). This is the six-tap response (k0,k1,k2,k2,k1,k0) delayed by four samples, in two's complement and sign-extended to the output width.
- R6: coef_pack carries the three weights as 18-bit signed fields: bits [17:0] are k0 (outer pair), [35:18] are k1 (middle pair) and [53:36] are k2 (centre pair).
- R7: The pre-adder keeps one extra bit, so the sum of any two 16-bit samples, including -32768 + -32768 and 32767 + 32767, multiplies and accumulates with no wrap-around.
- R8: Cycles with in_valid low, whatever in_data carries, do not change the history or the result.
- R9: When a waiting result is taken (out_ready 1) and no new sample is accepted in that cycle, out_valid is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample stream valid |
| in_ready | output | 1 | Sample stream ready |
| in_data | input | 16 | Signed input sample |
| coef_pack | input | 54 | Three signed 18-bit weights, k0 in the low field |
| out_valid | output | 1 | Result stream valid |
| out_ready | input | 1 | Result stream ready |
| out_data | output | 48 | Signed filtered result |

## Verification
An impulse with three distinct weights plays the response back one tap at a time, so a swapped field or a miswired pair shows up at a known result index. Constant extreme samples with extreme weights separate a correct pre-adder width from one that wraps. Long random streams, with random idle gaps that carry junk data and random back-pressure, check that the arithmetic depends only on the accepted samples, that stalled results hold and that draining clears valid. A reset in the middle of a stream checks that the old history is gone.

// File: rtl/symfir_pkg.sv
package symfir_pkg;

  localparam int unsigned SMP_W_DEF  = 16;
  localparam int unsigned COEF_W_DEF = 18;
  localparam int unsigned ACC_W_DEF  = 48;
  localparam int unsigned PAIRS_DEF  = 3;

  // delay-line registers needed for a folded filter with the given pair count
  function automatic int unsigned line_depth(input int unsigned pairs);
    return 2 * pairs - 1;
  endfunction

  // width of a pre-added sample times a weight
  function automatic int unsigned prod_width(input int unsigned smp_w,
                                             input int unsigned coef_w);
    return smp_w + 1 + coef_w;
  endfunction

endpackage

// File: rtl/symfir_flow.sv
module symfir_flow (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output logic step
);

  logic beat_q;

  assign in_ready  = !beat_q || out_ready;
  assign step      = in_valid && in_ready;
  assign out_valid = beat_q;

  always_ff @(posedge clk) begin
    if (rst)            beat_q <= 1'b0;
    else if (step)      beat_q <= 1'b1;
    else if (out_ready) beat_q <= 1'b0;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) $past(rst) |-> !out_valid);

  // R2
  stall_block_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !step);

  // R3
  beat_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    step |=> out_valid);

  // R4
  hold_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid);

  // R9
  drain_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

endmodule

// File: rtl/symfir_tapline.sv
module symfir_tapline #(
  parameter int unsigned SMP_W = 16,
  parameter int unsigned PAIRS = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        step,
  input  logic [SMP_W-1:0]            din,
  output logic [PAIRS-1:0][SMP_W-1:0] near_op,
  output logic [SMP_W-1:0]            far_op
);

  localparam int unsigned DEPTH = symfir_pkg::line_depth(PAIRS);

  logic [DEPTH-1:0][SMP_W-1:0] line_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
    end else if (step) begin
      line_q[0] <= din;
      for (int i = 1; i < DEPTH; i++) line_q[i] <= line_q[i-1];
    end
  end

  // pair j reads the line two steps further along than pair j-1
  for (genvar j = 0; j < PAIRS; j++) begin : g_near
    if (j == 0) begin : g_head
      assign near_op[j] = din;
    end else begin : g_tap
      assign near_op[j] = line_q[2*j-1];
    end
  end

  // the far end of the line is the mirrored partner of every pair
  assign far_op = line_q[DEPTH-1];

  // R8
  tap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(line_q));

  if (DEPTH > 1) begin : g_shift_chk
    // R5
    tap_shift_chk: assert property (@(posedge clk) disable iff (rst)
      step |=> line_q[DEPTH-1] == $past(line_q[DEPTH-2]));
  end

endmodule

// File: rtl/symfir_mulstage.sv
module symfir_mulstage #(
  parameter int unsigned SMP_W  = 16,
  parameter int unsigned COEF_W = 18,
  parameter int unsigned PROD_W = symfir_pkg::prod_width(SMP_W, COEF_W)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     step,
  input  logic [SMP_W-1:0]         op_a,
  input  logic [SMP_W-1:0]         op_b,
  input  logic [COEF_W-1:0]        weight,
  output logic signed [PROD_W-1:0] prod
);

  logic signed [SMP_W:0]    pre_q;
  logic signed [PROD_W-1:0] prod_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q  <= '0;
      prod_q <= '0;
    end else if (step) begin
      pre_q  <= $signed({op_a[SMP_W-1], op_a}) + $signed({op_b[SMP_W-1], op_b});
      prod_q <= pre_q * $signed(weight);
    end
  end

  assign prod = prod_q;

  // R7
  preadd_neg_chk: assert property (@(posedge clk) disable iff (rst)
    (step && op_a[SMP_W-1] && op_b[SMP_W-1]) |=> pre_q[SMP_W]);

  // R7
  preadd_pos_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !op_a[SMP_W-1] && !op_b[SMP_W-1]) |=> !pre_q[SMP_W]);

endmodule

// File: rtl/symfir_sumchain.sv
module symfir_sumchain #(
  parameter int unsigned PROD_W = 35,
  parameter int unsigned ACC_W  = 48,
  parameter int unsigned PAIRS  = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         step,
  input  logic [PAIRS-1:0][PROD_W-1:0] prods,
  output logic [ACC_W-1:0]             total
);

  localparam int unsigned EXT_W = ACC_W - PROD_W;

  logic [PAIRS-1:0][ACC_W-1:0] part_q;
  logic [PAIRS-1:0][ACC_W-1:0] wide;

  for (genvar j = 0; j < PAIRS; j++) begin : g_stage
    assign wide[j] = {{EXT_W{prods[j][PROD_W-1]}}, prods[j]};
    if (j == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst)       part_q[j] <= '0;
        else if (step) part_q[j] <= wide[j];
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst)       part_q[j] <= '0;
        else if (step) part_q[j] <= part_q[j-1] + wide[j];
      end
    end
  end

  assign total = part_q[PAIRS-1];

  // R1
  chain_reset_chk: assert property (@(posedge clk) $past(rst) |-> total == '0);

  // R4
  chain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(total));

endmodule

// File: rtl/symfir_top.sv
module symfir_top #(
  parameter int unsigned SMP_W  = symfir_pkg::SMP_W_DEF,
  parameter int unsigned COEF_W = symfir_pkg::COEF_W_DEF,
  parameter int unsigned ACC_W  = symfir_pkg::ACC_W_DEF,
  parameter int unsigned PAIRS  = symfir_pkg::PAIRS_DEF
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [SMP_W-1:0]        in_data,
  input  logic [PAIRS*COEF_W-1:0] coef_pack,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [ACC_W-1:0]        out_data
);

  localparam int unsigned PROD_W = symfir_pkg::prod_width(SMP_W, COEF_W);

  logic                         step;
  logic [PAIRS-1:0][SMP_W-1:0]  near_op;
  logic [SMP_W-1:0]             far_op;
  logic [PAIRS-1:0][PROD_W-1:0] prods;

  symfir_flow u_flow (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .step      (step)
  );

  symfir_tapline #(.SMP_W(SMP_W), .PAIRS(PAIRS)) u_line (
    .clk     (clk),
    .rst     (rst),
    .step    (step),
    .din     (in_data),
    .near_op (near_op),
    .far_op  (far_op)
  );

  for (genvar j = 0; j < PAIRS; j++) begin : g_pair
    logic signed [PROD_W-1:0] p;
    symfir_mulstage #(.SMP_W(SMP_W), .COEF_W(COEF_W), .PROD_W(PROD_W)) u_mul (
      .clk    (clk),
      .rst    (rst),
      .step   (step),
      .op_a   (near_op[j]),
      .op_b   (far_op),
      .weight (coef_pack[j*COEF_W +: COEF_W]),
      .prod   (p)
    );
    assign prods[j] = p;
  end

  symfir_sumchain #(.PROD_W(PROD_W), .ACC_W(ACC_W), .PAIRS(PAIRS)) u_sum (
    .clk   (clk),
    .rst   (rst),
    .step  (step),
    .prods (prods),
    .total (out_data)
  );

  // R4
  stall_data_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> $stable(out_data));

endmodule

// File: tb/symfir_top_tb_top.sv
module symfir_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic [53:0] coef_pack = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [47:0] out_data;

  always #10 clk = ~clk;

  symfir_top dut_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .coef_pack (coef_pack),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  int     n_chk = 0;
  int     n_bad = 0;
  int     hist[10];
  int     kw[3];
  longint exp_val;
  bit     expect_beat, expect_drain, held_v;
  logic [47:0] held;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint model();
    longint s;
    int h[6];
    h = '{kw[0], kw[1], kw[2], kw[2], kw[1], kw[0]};
    s = 0;
    for (int i = 0; i < 6; i++) s += longint'(h[i]) * longint'(hist[4+i]);
    return s;
  endfunction

  task automatic set_coefs(input int a, input int b, input int c);
    kw[0] = a; kw[1] = b; kw[2] = c;
    coef_pack = {c[17:0], b[17:0], a[17:0]};
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 10; i++) hist[i] = 0;
    expect_beat = 0; expect_drain = 0; held_v = 0;
    #1;
    // R1
    check(out_valid == 1'b0, "R1 out_valid", longint'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready", longint'(in_ready), 1);
    check(out_data == '0, "R1 out_data", longint'($signed(out_data)), 0);
  endtask

  task automatic cycle(input bit iv, input logic [15:0] d, input bit ordy, input string tag);
    longint act;
    @(negedge clk);
    in_valid = iv; in_data = d; out_ready = ordy;
    #1;
    act = longint'($signed(out_data));
    if (expect_beat) check(out_valid == 1'b1, "R3 beat after accept", longint'(out_valid), 1);
    if (expect_drain) check(out_valid == 1'b0, "R9 drained valid", longint'(out_valid), 0);
    if (held_v) check(out_data == held, "R4 held data", act, longint'($signed(held)));
    expect_beat = 0; expect_drain = 0; held_v = 0;
    if (out_valid && out_ready) begin
      check(act == exp_val, tag, act, exp_val);
    end
    if (out_valid && !out_ready) begin
      held = out_data; held_v = 1;
      check(in_ready == 1'b0, "R2 ready low on stall", longint'(in_ready), 0);
    end
    if (in_valid && in_ready) begin
      for (int i = 9; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = int'($signed(d));
      exp_val = model();
      expect_beat = 1;
    end else if (out_valid && out_ready) begin
      expect_drain = 1;
    end
  endtask

  function automatic int rnd_coef();
    logic [17:0] r;
    r = 18'($urandom);
    return int'($signed(r));
  endfunction

  initial begin
    do_reset();

    // R6: impulse with distinct weights plays back k0,k1,k2,k2,k1,k0
    set_coefs(3, -7, 11);
    do_reset();
    cycle(1'b1, 16'd1, 1'b1, "R6 impulse");
    for (int i = 0; i < 11; i++) cycle(1'b1, 16'd0, 1'b1, "R6 impulse");
    cycle(1'b0, 16'd0, 1'b1, "R6 impulse");

    // R7: extreme samples with extreme weights
    set_coefs(-131072, -131072, -131072);
    do_reset();
    for (int i = 0; i < 12; i++) cycle(1'b1, 16'h8000, 1'b1, "R7 neg extreme");
    set_coefs(131071, -131072, 131071);
    do_reset();
    for (int i = 0; i < 12; i++) cycle(1'b1, 16'h7FFF, 1'b1, "R7 pos extreme");
    for (int i = 0; i < 12; i++) cycle(1'b1, (i % 2) ? 16'h7FFF : 16'h8000, 1'b1, "R7 alternating");
    cycle(1'b0, 16'd0, 1'b1, "R7 drain");

    // R5: step input with full throughput
    set_coefs(1000, -2000, 4000);
    do_reset();
    for (int i = 0; i < 14; i++) cycle(1'b1, 16'd1234, 1'b1, "R5 step");

    // R5 R8 R2 R4 R9: random streams, junk in idle cycles, back-pressure
    for (int s = 0; s < 4; s++) begin
      set_coefs(rnd_coef(), rnd_coef(), rnd_coef());
      do_reset();
      for (int c = 0; c < 3000; c++) begin
        cycle(($urandom % 4) != 0, 16'($urandom), ($urandom % 3) != 0,
              "R8 random stream");
      end
      // R1: reset mid-stream, then the history must read as zeros
      do_reset();
      for (int c = 0; c < 12; c++) cycle(1'b1, 16'($urandom), 1'b1, "R1 after reset");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule